// File: doc/BRIEF.md
# Power-Up Reset Sequencer with Oscillator Qualification

This block controls the chip's reset release after a supply event. When the power-on or low-voltage detector fires, the sequencer first qualifies the crystal oscillator. It counts oscillator edges inside fixed measurement windows that are timed on the internal self-clock. The first window that reaches the required edge count selects the oscillator. If a fixed number of windows pass without success, the block gives up on the oscillator and sequences on the self-clock, and it raises a flag to report that fallback.

Once the clock is chosen, the block pulls the bidirectional reset pad low for a fixed number of cycles and then lets it go. It then waits a further fixed interval and reads the pad. If something outside the chip still holds the pad low, internal reset stays asserted until the pad reads high. A new supply event at any point sends the sequencer back to oscillator qualification. The analog detectors and the clock multiplexer are outside this block. Oscillator edges arrive as a synchronized one-cycle pulse, `osc_tick`. The pad level arrives on `pin_in`.

Top module: `por_clock_seq`

## Requirements
- R1: In the cycle after any cycle in which `por_det` or `lvr_det` is high, `rst_int` is 1 and `pin_drive_en`, `osc_sel` and `self_mode` are all 0. Qualification then restarts from window 0.
- R2: A window lasts WIN_LEN cycles. It passes on the clock edge at which the OSC_GOOD-th `osc_tick` of that window is sampled. From that edge on, `pin_drive_en` is 1 and `osc_sel` is 1.
- R3: Suppose MAX_WIN consecutive windows end without passing. At the final edge of the last window, the drive phase starts with `self_mode` 1 and `osc_sel` 0.
- R4: `pin_drive_en` stays 1 for exactly PIN_LOW consecutive cycles and then returns to 0.
- R5: After the drive phase, the block counts WAIT_LEN cycles. If `pin_in` is high at the last of them, `rst_int` falls on that edge.
- R6: If `pin_in` is low at that point, `rst_int` stays 1 and falls on the first edge at which `pin_in` is sampled high. `rst_int` never falls at an edge where `pin_in` was low.
- R7: `osc_sel` and `self_mode` are never both 1.
- R8: `rst_int` is 1 whenever `pin_drive_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (self-clock or selected clock) |
| por_det | input | 1 | Power-on detector output, active high |
| lvr_det | input | 1 | Low-voltage detector output, active high |
| osc_tick | input | 1 | One-cycle pulse per synchronized oscillator edge |
| pin_in | input | 1 | Sensed level of the reset pad |
| rst_int | output | 1 | Internal reset, active high |
| pin_drive_en | output | 1 | Pulls the reset pad low when 1 |
| osc_sel | output | 1 | 1 when the oscillator was qualified |
| self_mode | output | 1 | 1 when the sequence fell back to the self-clock |

## Verification
Suppose the window or edge counter is wrong. Then the first `pin_drive_en` rise moves by at least one cycle relative to the edge-by-edge model of the tick stream, or the wrong one of `osc_sel` and `self_mode` rises. Either effect shows on the edge where the drive phase should start. A wrong phase counter changes the measured width of the pad pulse or the gap before `rst_int` falls, and this shows within one phase. A state that ignores the pad releases `rst_int` while the pad is still low. A state that ignores a detector event keeps `pin_drive_en` or `osc_sel` high in the cycle after the event.

// File: rtl/por_clock_seq.sv
module por_clock_seq #(
  parameter int WIN_LEN  = 1024,
  parameter int OSC_GOOD = 512,
  parameter int MAX_WIN  = 50,
  parameter int PIN_LOW  = 128,
  parameter int WAIT_LEN = 64
) (
  input  logic clk,
  input  logic por_det,
  input  logic lvr_det,
  input  logic osc_tick,
  input  logic pin_in,
  output logic rst_int,
  output logic pin_drive_en,
  output logic osc_sel,
  output logic self_mode
);
  localparam int MAXC = (WIN_LEN > PIN_LOW) ? ((WIN_LEN > WAIT_LEN) ? WIN_LEN : WAIT_LEN)
                                            : ((PIN_LOW > WAIT_LEN) ? PIN_LOW : WAIT_LEN);
  localparam int CW = $clog2(MAXC + 1);
  localparam int EW = $clog2(OSC_GOOD + 1);
  localparam int TW = $clog2(MAX_WIN + 1);

  typedef enum logic [2:0] {S_CHECK, S_DRIVE, S_WAIT, S_HOLD, S_RUN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [EW-1:0] edges;
  logic [TW-1:0] tries;

  wire restart = por_det | lvr_det;

  always_ff @(posedge clk) begin
    if (restart) begin
      st        <= S_CHECK;
      cnt       <= '0;
      edges     <= '0;
      tries     <= '0;
      osc_sel   <= 1'b0;
      self_mode <= 1'b0;
    end else begin
      case (st)
        S_CHECK:
          if (osc_tick && edges == EW'(OSC_GOOD - 1)) begin
            st      <= S_DRIVE;
            cnt     <= '0;
            osc_sel <= 1'b1;
          end else if (cnt == CW'(WIN_LEN - 1)) begin
            cnt   <= '0;
            edges <= '0;
            if (tries == TW'(MAX_WIN - 1)) begin
              st        <= S_DRIVE;
              self_mode <= 1'b1;
            end else begin
              tries <= tries + 1'b1;
            end
          end else begin
            cnt   <= cnt + 1'b1;
            edges <= edges + EW'(osc_tick);
          end
        S_DRIVE:
          if (cnt == CW'(PIN_LOW - 1)) begin
            st  <= S_WAIT;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_WAIT:
          if (cnt == CW'(WAIT_LEN - 1)) st <= pin_in ? S_RUN : S_HOLD;
          else cnt <= cnt + 1'b1;
        S_HOLD:
          if (pin_in) st <= S_RUN;
        default: ;
      endcase
    end
  end

  assign rst_int      = (st != S_RUN);
  assign pin_drive_en = (st == S_DRIVE);
endmodule

// File: rtl/por_clock_seq_chk.sv
module por_clock_seq_chk #(
  parameter int PIN_LOW = 128
) (
  input logic clk,
  input logic por_det,
  input logic lvr_det,
  input logic pin_in,
  input logic rst_int,
  input logic pin_drive_en,
  input logic osc_sel,
  input logic self_mode
);
  wire restart = por_det | lvr_det;
  logic armed = 1'b0;
  int unsigned dcnt = 0;

  always_ff @(posedge clk) begin
    if (restart) armed <= 1'b1;
    dcnt <= pin_drive_en ? dcnt + 1 : 0;
  end

  p_restart_r1: assert property (@(posedge clk)
    restart |=> (rst_int && !pin_drive_en && !osc_sel && !self_mode));

  p_drive_width_r4: assert property (@(posedge clk) disable iff (restart || !armed)
    ($fell(pin_drive_en) && !$past(restart)) |-> (dcnt == PIN_LOW));

  p_release_pad_high_r6: assert property (@(posedge clk) disable iff (restart || !armed)
    $fell(rst_int) |-> $past(pin_in));

  p_modes_exclusive_r7: assert property (@(posedge clk) disable iff (restart || !armed)
    !(osc_sel && self_mode));

  p_drive_in_reset_r8: assert property (@(posedge clk) disable iff (restart || !armed)
    pin_drive_en |-> rst_int);
endmodule

bind por_clock_seq por_clock_seq_chk #(.PIN_LOW(PIN_LOW)) u_chk (
  .clk(clk), .por_det(por_det), .lvr_det(lvr_det), .pin_in(pin_in),
  .rst_int(rst_int), .pin_drive_en(pin_drive_en), .osc_sel(osc_sel), .self_mode(self_mode)
);

// File: tb/tb_por_clock_seq.sv
`timescale 1ns/1ps
module tb_por_clock_seq;
  localparam int WIN_LEN = 40, OSC_GOOD = 20, MAX_WIN = 50, PIN_LOW = 128, WAIT_LEN = 64;

  logic clk = 1'b0;
  logic por_det = 1'b0, lvr_det = 1'b0, osc_tick = 1'b0, ext_low = 1'b0;
  logic rst_int, pin_drive_en, osc_sel, self_mode;
  wire  pin_in = ~(pin_drive_en | ext_low);
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  por_clock_seq #(.WIN_LEN(WIN_LEN), .OSC_GOOD(OSC_GOOD), .MAX_WIN(MAX_WIN),
                  .PIN_LOW(PIN_LOW), .WAIT_LEN(WAIT_LEN)) dut (
    .clk(clk), .por_det(por_det), .lvr_det(lvr_det), .osc_tick(osc_tick), .pin_in(pin_in),
    .rst_int(rst_int), .pin_drive_en(pin_drive_en), .osc_sel(osc_sel), .self_mode(self_mode));

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit rnd_tick(int prob);
    return ($urandom % 100) < prob;
  endfunction

  task automatic restart(bit use_lvr);
    @(negedge clk);
    osc_tick = 1'b0;
    if (use_lvr) lvr_det = 1'b1; else por_det = 1'b1;
    repeat (2) @(negedge clk);
    check(rst_int && !pin_drive_en && !osc_sel && !self_mode, "R1",
          {rst_int, pin_drive_en, osc_sel, self_mode}, 4'b1000);
    por_det = 1'b0;
    lvr_det = 1'b0;
  endtask

  task automatic run_check(int prob);
    int wc = 0, ec = 0, tr = 0, e = 0;
    int pred = -1, act = -1;
    bit fb = 1'b0;
    while ((pred < 0 || act < 0) && e < 5000) begin
      osc_tick = rnd_tick(prob);
      e++;
      if (pred < 0) begin
        if (osc_tick && ec == OSC_GOOD - 1) pred = e;
        else if (wc == WIN_LEN - 1) begin
          wc = 0; ec = 0;
          if (tr == MAX_WIN - 1) begin pred = e; fb = 1'b1; end
          else tr++;
        end else begin
          wc++; ec += int'(osc_tick);
        end
      end
      @(negedge clk);
      if (act < 0 && pin_drive_en) begin
        act = e;
        check(osc_sel == !fb && self_mode == fb, fb ? "R3" : "R2",
              {osc_sel, self_mode}, {!fb, fb});
        check(rst_int, "R8", rst_int, 1);
      end
    end
    osc_tick = 1'b0;
    check(act == pred, fb ? "R3" : "R2", act, pred);
  endtask

  task automatic run_tail(int hold);
    int w = 0, d = 1;
    ext_low = (hold > 0);
    while (pin_drive_en && d < 1000) begin @(negedge clk); if (pin_drive_en) d++; end
    check(d == PIN_LOW, "R4", d, PIN_LOW);
    while (rst_int && w < WAIT_LEN + hold + 10) begin
      if (hold > 0 && w == WAIT_LEN) check(rst_int, "R6", rst_int, 1);
      if (hold > 0 && w == WAIT_LEN + hold) ext_low = 1'b0;
      @(negedge clk);
      w++;
    end
    if (hold > 0) check(w == WAIT_LEN + hold + 1, "R6", w, WAIT_LEN + hold + 1);
    else          check(w == WAIT_LEN, "R5", w, WAIT_LEN);
    check(!(osc_sel && self_mode), "R7", {osc_sel, self_mode}, 0);
    ext_low = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    restart(1'b0);
    run_check(100);
    run_tail(0);
    restart(1'b1);
    run_check(0);
    run_tail(7);
    restart(1'b0);
    run_check(100);
    repeat (PIN_LOW + 10) @(negedge clk);
    lvr_det = 1'b1;
    @(negedge clk);
    lvr_det = 1'b0;
    check(rst_int && !pin_drive_en && !osc_sel && !self_mode, "R1",
          {rst_int, pin_drive_en, osc_sel, self_mode}, 4'b1000);
    run_check(100);
    run_tail(0);
    for (int i = 0; i < 8; i++) begin
      int p = 20 + int'($urandom % 60);
      int h = (($urandom % 2) == 0) ? 0 : 1 + int'($urandom % 30);
      restart(($urandom % 2) == 1);
      run_check(p);
      run_tail(h);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule